// File: doc/BRIEF.md
# Nibble-Coded Serial Link with Comma Framing

This block is a matched transmit and receive pair for a one-bit serial line. Both ends run on one shared bit clock. The transmitter runs on a fixed ten-cycle beat. On each beat it takes one byte from an 8-bit port and splits it into two nibbles. Each nibble becomes a 5-bit symbol from a fixed table, so each byte becomes a 10-bit line word. The word is shifted out one bit per clock. On any beat the user may ask for a comma instead of a byte. The comma is a 10-bit pattern that no data word can form.

The receiver shifts the line in and compares every 10-bit window against the comma, one window per clock. Each comma it finds restarts its word boundary, so the link frames itself again after a slip. After the first comma, every ten bits are decoded back into a byte with a one-cycle strobe. A symbol that is not in the table raises an error flag. The serial output and the serial input are separate ports, so the receiver can be fed from its own transmitter or from any other source.

Top module: `nbl_link`

## Requirements
- R1: Each byte becomes one 10-bit word on `ser_out`, most significant bit first. The high nibble's symbol goes first, then the low nibble's symbol. Nibble values 0 to 15 map in order to these symbols: 00101, 00110, 01001, 01010, 01011, 01100, 01101, 01110, 10001, 10010, 10011, 10100, 10101, 10110, 11001, 11010.
- R2: In a stream of data words with no comma between them, `ser_out` never holds the same value for more than 4 consecutive bits. Within one symbol the limit is 3.
- R3: `tx_load` is high for exactly one cycle in every ten. `tx_data` and `tx_comma` are sampled at the clock edge that ends that cycle. The first bit of the new word appears on `ser_out` right after that edge.
- R4: When `tx_comma` is high at a load edge, the word sent is 1111100000 and `tx_data` is ignored.
- R5: The receiver finds the comma at any bit offset of `ser_in`. It takes the next ten bits after the comma as one word, and it restarts this framing each time another comma arrives.
- R6: `rx_valid` stays low from reset until the first comma has been received.
- R7: A received comma produces no strobe on `rx_valid`.
- R8: Once framed, each received data word raises `rx_valid` for one cycle, starting right after the edge that samples its tenth bit. At that time `rx_data` holds the decoded byte.
- R9: `rx_err` goes high with `rx_valid` when either 5-bit symbol of the word is not in the R1 table. It is low otherwise.
- R10: While `rst_n` is low: `tx_load` is high, `ser_out` is low, and `rx_valid` and `rx_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock shared by both ends |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_data | input | 8 | Byte to send, sampled at the load edge |
| tx_comma | input | 1 | Send the comma instead of `tx_data` |
| tx_load | output | 1 | High in the cycle whose ending edge takes the next word |
| ser_out | output | 1 | Serial line from the transmitter |
| ser_in | input | 1 | Serial line into the receiver |
| rx_data | output | 8 | Decoded byte |
| rx_valid | output | 1 | One-cycle strobe for a decoded data word |
| rx_err | output | 1 | Illegal symbol in the word strobed by `rx_valid` |

## Verification
The run-length assertion takes for granted that the transmitter sends only table symbols between commas. It therefore starts counting afresh whenever a comma word is on the line. The receiver assertions take for granted that `ser_in` forms 1111100000 only where a comma was really sent. The bench keeps to this: the junk bits and illegal symbols it injects are chosen so that no unintended comma pattern appears. It also places injected commas at offsets that differ from the current framing, to exercise re-alignment.

// File: rtl/nbl_pkg.sv
package nbl_pkg;
  localparam int NIB_W  = 4;
  localparam int SYM_W  = 5;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int WORD_W = 2 * SYM_W;
  localparam logic [WORD_W-1:0] COMMA = 10'b11111_00000;

  typedef struct packed {
    logic             legal;
    logic [NIB_W-1:0] nib;
  } dec_t;

  // Symbols: leading and trailing runs at most 2, inner runs at most 3.
  function automatic logic [SYM_W-1:0] enc_nib(input logic [NIB_W-1:0] n);
    logic [SYM_W-1:0] s;
    case (n)
      4'h0: s = 5'b00101;
      4'h1: s = 5'b00110;
      4'h2: s = 5'b01001;
      4'h3: s = 5'b01010;
      4'h4: s = 5'b01011;
      4'h5: s = 5'b01100;
      4'h6: s = 5'b01101;
      4'h7: s = 5'b01110;
      4'h8: s = 5'b10001;
      4'h9: s = 5'b10010;
      4'hA: s = 5'b10011;
      4'hB: s = 5'b10100;
      4'hC: s = 5'b10101;
      4'hD: s = 5'b10110;
      4'hE: s = 5'b11001;
      default: s = 5'b11010;
    endcase
    return s;
  endfunction

  function automatic dec_t dec_sym(input logic [SYM_W-1:0] s);
    dec_t d;
    d.legal = 1'b1;
    d.nib   = '0;
    case (s)
      5'b00101: d.nib = 4'h0;
      5'b00110: d.nib = 4'h1;
      5'b01001: d.nib = 4'h2;
      5'b01010: d.nib = 4'h3;
      5'b01011: d.nib = 4'h4;
      5'b01100: d.nib = 4'h5;
      5'b01101: d.nib = 4'h6;
      5'b01110: d.nib = 4'h7;
      5'b10001: d.nib = 4'h8;
      5'b10010: d.nib = 4'h9;
      5'b10011: d.nib = 4'hA;
      5'b10100: d.nib = 4'hB;
      5'b10101: d.nib = 4'hC;
      5'b10110: d.nib = 4'hD;
      5'b11001: d.nib = 4'hE;
      5'b11010: d.nib = 4'hF;
      default:  d.legal = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/nbl_tx.sv
module nbl_tx
  import nbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] data_i,
  input  logic              comma_i,
  output logic              load_o,
  output logic              bit_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              comma_q, comma_d;

  assign load_o = (cnt_q == LAST);
  assign bit_o  = sh_q[WORD_W-1];

  always_comb begin
    cnt_d   = cnt_q + CNT_W'(1);
    sh_d    = {sh_q[WORD_W-2:0], 1'b0};
    comma_d = comma_q;
    if (load_o) begin
      cnt_d   = '0;
      comma_d = comma_i;
      if (comma_i) sh_d = COMMA;
      else         sh_d = {enc_nib(data_i[BYTE_W-1:NIB_W]), enc_nib(data_i[NIB_W-1:0])};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= LAST;
      sh_q    <= '0;
      comma_q <= 1'b1;
    end else begin
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      comma_q <= comma_d;
    end
  end

  // Checker state: run length of data bits and spacing of load strobes.
  logic [CNT_W-1:0] ck_gap;
  logic             ck_seen;
  logic [2:0]       ck_run;
  logic             ck_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_gap  <= '0;
      ck_seen <= 1'b0;
      ck_run  <= '0;
      ck_prev <= 1'b0;
    end else begin
      if (load_o) begin
        ck_gap  <= '0;
        ck_seen <= 1'b1;
      end else if (ck_gap != LAST) begin
        ck_gap  <= ck_gap + CNT_W'(1);
      end
      if (comma_q)                             ck_run <= '0;
      else if (ck_run == '0 || bit_o != ck_prev) ck_run <= 3'd1;
      else if (ck_run != 3'd7)                 ck_run <= ck_run + 3'd1;
      ck_prev <= bit_o;
    end
  end

  AST_TX_RUN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    ck_run <= 3'd4); // R2
  AST_TX_LOAD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && ck_seen) |-> (ck_gap == LAST)); // R3
  AST_TX_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o); // R3
endmodule

// File: rtl/nbl_rx_align.sv
module nbl_rx_align
  import nbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o,
  output logic              frame_o,
  output logic              comma_o,
  output logic              locked_o
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  phase_q, phase_d;
  logic              locked_q, locked_d;

  assign sh_d     = {sh_q[WORD_W-2:0], bit_i};
  assign word_o   = sh_d;
  assign comma_o  = (sh_d == COMMA);
  assign frame_o  = locked_q && !comma_o && (phase_q == LAST);
  assign locked_o = locked_q;

  always_comb begin
    locked_d = locked_q | comma_o;
    phase_d  = phase_q;
    if (comma_o || frame_o) phase_d = '0;
    else if (locked_q)      phase_d = phase_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      phase_q  <= '0;
      locked_q <= 1'b0;
    end else begin
      sh_q     <= sh_d;
      phase_q  <= phase_d;
      locked_q <= locked_d;
    end
  end

  AST_ALIGN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    comma_o |=> (phase_q == '0)); // R5
  AST_ALIGN_LOCK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    locked_q |=> locked_q); // R6
  AST_ALIGN_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_o |=> !frame_o); // R8
endmodule

// File: rtl/nbl_rx_decode.sv
module nbl_rx_decode
  import nbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_i,
  input  logic              frame_i,
  output logic [BYTE_W-1:0] data_o,
  output logic              valid_o,
  output logic              err_o
);
  dec_t              hi, lo;
  logic [BYTE_W-1:0] data_d;
  logic              valid_d, err_d;

  assign hi = dec_sym(word_i[WORD_W-1:SYM_W]);
  assign lo = dec_sym(word_i[SYM_W-1:0]);

  always_comb begin
    valid_d = frame_i;
    data_d  = data_o;
    err_d   = 1'b0;
    if (frame_i) begin
      data_d = {hi.nib, lo.nib};
      err_d  = !(hi.legal && lo.legal);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      data_o  <= data_d;
      valid_o <= valid_d;
      err_o   <= err_d;
    end
  end

  AST_DEC_ERR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> valid_o); // R9
  AST_DEC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o); // R8
endmodule

// File: rtl/nbl_link.sv
module nbl_link
  import nbl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_comma,
  output logic              tx_load,
  output logic              ser_out,
  input  logic              ser_in,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              rx_err
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [WORD_W-1:0] rx_word;
  logic              rx_frame, rx_comma, rx_locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  nbl_tx u_tx (
    .clk(clk), .rst_n(rst_int_n), .data_i(tx_data), .comma_i(tx_comma),
    .load_o(tx_load), .bit_o(ser_out));

  nbl_rx_align u_align (
    .clk(clk), .rst_n(rst_int_n), .bit_i(ser_in), .word_o(rx_word),
    .frame_o(rx_frame), .comma_o(rx_comma), .locked_o(rx_locked));

  nbl_rx_decode u_dec (
    .clk(clk), .rst_n(rst_int_n), .word_i(rx_word), .frame_i(rx_frame),
    .data_o(rx_data), .valid_o(rx_valid), .err_o(rx_err));

  AST_LINK_QUIET_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_int_n)
    !rx_locked |-> !rx_valid); // R6
  AST_LINK_COMMA_NO_BYTE: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_comma |=> !rx_valid); // R7
endmodule

// File: tb/nbl_link_bench.sv
`timescale 1ns/1ps
module nbl_link_bench;
  localparam real CLK_P = 4.0;
  localparam int  NV = 12;
  // {comma, byte}
  localparam logic [8:0] VEC [NV] = '{
    9'h0A5, 9'h100, 9'h000, 9'h0FF, 9'h00F, 9'h0F0,
    9'h05A, 9'h100, 9'h03C, 9'h096, 9'h0C3, 9'h081};
  localparam logic [4:0] SYM [16] = '{
    5'b00101, 5'b00110, 5'b01001, 5'b01010, 5'b01011, 5'b01100, 5'b01101, 5'b01110,
    5'b10001, 5'b10010, 5'b10011, 5'b10100, 5'b10101, 5'b10110, 5'b11001, 5'b11010};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] tx_data = '0;
  logic tx_comma = 1'b0;
  logic tx_load, ser_out, rx_valid, rx_err;
  logic [7:0] rx_data;
  logic use_loop = 1'b1;
  logic inj = 1'b0;
  logic ser_in;
  int checks = 0;
  int errors = 0;
  logic mon_en = 1'b0;
  logic mon_prev = 1'b0;
  int run_len = 0;
  int max_run = 0;

  assign ser_in = use_loop ? ser_out : inj;
  always #(CLK_P/2) clk = ~clk;

  nbl_link u_nbl_link (
    .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_comma(tx_comma),
    .tx_load(tx_load), .ser_out(ser_out), .ser_in(ser_in),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_err(rx_err));

  always @(negedge clk) begin
    if (!mon_en) run_len = 0;
    else begin
      if (run_len != 0 && ser_out == mon_prev) run_len++;
      else run_len = 1;
      mon_prev = ser_out;
      if (run_len > max_run) max_run = run_len;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_load();
    @(negedge clk);
    while (!tx_load) @(negedge clk);
  endtask

  task automatic inj_word(input logic [9:0] w);
    for (int i = 9; i >= 0; i--) begin
      inj = w[i];
      @(negedge clk);
    end
  endtask

  task automatic inj_bit(input logic b);
    inj = b;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic locked_m;
    logic [9:0] cap;
    int loads;
    // R10 reset state
    repeat (3) @(negedge clk);
    chk(tx_load == 1'b1, "R10 tx_load", int'(tx_load), 1);
    chk(ser_out == 1'b0, "R10 ser_out", int'(ser_out), 0);
    chk(rx_valid == 1'b0 && rx_err == 1'b0, "R10 rx flags", int'({rx_valid, rx_err}), 0);
    rst_n = 1'b1;

    // Vector table walk in loopback
    locked_m = 1'b0;
    for (int k = 0; k <= NV; k++) begin
      wait_load();
      if (k < NV) begin
        tx_comma = VEC[k][8];
        tx_data  = VEC[k][7:0];
      end else begin
        tx_comma = 1'b1;
        tx_data  = 8'h00;
      end
      @(negedge clk);
      if (k > 0) begin
        if (VEC[k-1][8]) begin
          chk(rx_valid == 1'b0, "R7 comma strobe", int'(rx_valid), 0);
          locked_m = 1'b1;
        end else if (!locked_m) begin
          chk(rx_valid == 1'b0, "R6 prelock strobe", int'(rx_valid), 0);
        end else begin
          chk(rx_valid == 1'b1 && rx_err == 1'b0 && rx_data == VEC[k-1][7:0],
              "R8 decoded byte", int'({rx_valid, rx_err, rx_data}),
              int'({2'b10, VEC[k-1][7:0]}));
        end
      end
    end

    // R1 and R3: capture one data word on the line
    wait_load();
    tx_comma = 1'b0;
    tx_data  = 8'h4B;
    loads = 0;
    for (int i = 9; i >= 0; i--) begin
      @(negedge clk);
      cap[i] = ser_out;
      if (tx_load) loads++;
    end
    chk(cap == {SYM[4], SYM[11]}, "R1 line word", int'(cap), int'({SYM[4], SYM[11]}));
    chk(loads == 1 && tx_load == 1'b1, "R3 load spacing", loads, 1);

    // R4: comma on the line, data ignored
    tx_comma = 1'b1;
    tx_data  = 8'h77;
    for (int i = 9; i >= 0; i--) begin
      @(negedge clk);
      cap[i] = ser_out;
    end
    chk(cap == 10'b1111100000, "R4 comma word", int'(cap), 10'h3E0);

    // R2 and R8: all byte values back to back
    for (int b = 0; b <= 256; b++) begin
      wait_load();
      if (b < 256) begin
        tx_comma = 1'b0;
        tx_data  = 8'(b);
        if (b == 1) mon_en = 1'b1;
      end else begin
        mon_en   = 1'b0;
        tx_comma = 1'b1;
      end
      @(negedge clk);
      if (b > 0)
        chk(rx_valid == 1'b1 && rx_err == 1'b0 && rx_data == 8'(b - 1),
            "R8 sweep byte", int'({rx_valid, rx_err, rx_data}), int'({2'b10, 8'(b - 1)}));
    end
    chk(max_run <= 4 && max_run >= 3, "R2 max run", max_run, 4);

    // Injected stream: framing at new offsets and illegal symbols
    @(negedge clk);
    use_loop = 1'b0;
    inj_bit(1'b1); inj_bit(1'b0); inj_bit(1'b1);
    inj_word(10'b1111100000);
    chk(rx_valid == 1'b0, "R7 injected comma", int'(rx_valid), 0);
    inj_word({SYM[7], SYM[3]});
    chk(rx_valid == 1'b1 && rx_err == 1'b0 && rx_data == 8'h73, "R5 first framing",
        int'({rx_valid, rx_err, rx_data}), 10'h273);
    inj_bit(1'b0); inj_bit(1'b1); inj_bit(1'b1); inj_bit(1'b0);
    inj_word(10'b1111100000);
    chk(rx_valid == 1'b0, "R7 realign comma", int'(rx_valid), 0);
    inj_word({SYM[14], SYM[9]});
    chk(rx_valid == 1'b1 && rx_err == 1'b0 && rx_data == 8'hE9, "R5 realigned",
        int'({rx_valid, rx_err, rx_data}), 10'h2E9);
    inj_word({5'b00000, SYM[1]});
    chk(rx_valid == 1'b1 && rx_err == 1'b1, "R9 illegal high", int'({rx_valid, rx_err}), 3);
    inj_word({SYM[2], 5'b11100});
    chk(rx_valid == 1'b1 && rx_err == 1'b1, "R9 illegal low", int'({rx_valid, rx_err}), 3);
    inj_word({SYM[5], SYM[6]});
    chk(rx_valid == 1'b1 && rx_err == 1'b0 && rx_data == 8'h56, "R9 legal clears",
        int'({rx_valid, rx_err, rx_data}), 10'h256);
    @(negedge clk);
    chk(rx_valid == 1'b0, "R8 strobe width", int'(rx_valid), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule